// File: doc/BRIEF.md
# Maskable Interrupt Latch with Acknowledge Read

This block collects interrupt events from a controller's housekeeping sources into an 8-bit pending register. An 8-bit enable mask filters them onto one active-low interrupt line. Two free-running cycle timers feed it. A one-second timer sets a tick bit. A thirty-millisecond autopoll timer, while a 16-bit poll-enable mask is nonzero, asks an external peripheral for data with a one-cycle `poll_req` pulse. The peripheral answers in the same cycle with a length, and with up to `REPLY_BYTES` bytes that the block keeps in its reply buffer.

Software drives the block with single-beat commands. Each command carries an opcode, an argument count and a 16-bit argument. An acknowledge command reads out the pending state as a byte stream and clears what it returned. If a peripheral reply is waiting, the stream is a flag byte followed by the stored reply bytes. If not, the stream is the whole pending byte. Other commands load the interrupt mask, load the autopoll mask or stop autopolling. A command whose argument count is wrong is dropped without effect.

Top module: `irq_ack_latch`

## Requirements
- R1: `irq_n` is 0 in every cycle in which the pending register ANDed with the interrupt mask is nonzero, and 1 otherwise.
- R2: After synchronous reset the pending register is 0, the interrupt mask is 8'h30 (bits 4 and 5 enabled), the autopoll mask is 0, `irq_n` is 1, `cmd_ready` is 1, and `rsp_valid` and `poll_req` are 0.
- R3: Pending bit 5 (tick) is set at clock edge number `TICK_MS*CYC_PER_MS` after reset and again every `TICK_MS*CYC_PER_MS` edges after that. Each deadline is counted from the previous deadline and not from any command.
- R4: While the autopoll mask is nonzero, `poll_req` pulses once every `POLL_MS*CYC_PER_MS` cycles. The pulse is suppressed while pending bit 4 is set or while a response stream still has beats to send. A pulse with nonzero `poll_len` stores `min(poll_len, REPLY_BYTES)` bytes from `poll_data` (byte i at bits 8i+7..8i) and sets pending bits 4 (peripheral data) and 2 (auto-poll).
- R5: An acknowledge (opcode 0, zero arguments) taken while bit 4 is pending returns the pending byte ANDed with 8'h14, followed by the stored reply bytes in order. It clears only bits 4 and 2 and the stored reply length.
- R6: An acknowledge taken while bit 4 is clear returns exactly one byte equal to the whole pending register and clears every pending bit.
- R7: The first response byte appears in the cycle after the command is accepted. One byte follows per cycle, with `rsp_last` high on the final byte. `cmd_ready` is 0 from the first beat up to, but not including, the final beat. A command is accepted only when `cmd_valid` and `cmd_ready` are both high.
- R8: Set-mask (opcode 1) loads `cmd_arg[7:0]` into the interrupt mask only when the argument count is exactly 1. An acknowledge with a nonzero argument count does nothing. Other commands with a wrong count are also dropped.
- R9: Set-poll (opcode 2, exactly 2 arguments) with a value different from the current autopoll mask loads it and restarts the poll period from the accept edge. The same value again leaves the period running. A value of zero stops polling, and so does poll-off (opcode 3, zero arguments).
- R10: When a tick or a poll capture lands in the same cycle as an acknowledge, the acknowledge returns the pending value from before that cycle, and the new event's bits remain set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Opcode: 0 acknowledge, 1 set mask, 2 set poll, 3 poll off |
| cmd_nargs | input | 3 | Number of argument bytes supplied |
| cmd_arg | input | 16 | Argument value |
| cmd_ready | output | 1 | Block can take a command this cycle |
| poll_req | output | 1 | Autopoll request pulse |
| poll_len | input | LEN_W | Reply length answered to `poll_req` (0 = no data) |
| poll_data | input | 8*REPLY_BYTES | Reply bytes answered to `poll_req` |
| rsp_valid | output | 1 | Response byte valid |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final byte of the response |
| irq_n | output | 1 | Active-low interrupt |

## Verification
An acknowledge can be accepted on the same edge at which the tick timer expires, or at which a poll capture latches new peripheral data. On that edge the block must both clear and set bits of the pending register. The bench tracks the remaining time of both timers in its own model. It then issues the acknowledge exactly on the expiring edge. It checks that the returned byte is the value from before the edge, that the interrupt line drops again afterwards, and that a following acknowledge returns the new bit. A per-cycle reference model also compares every output on each clock, so collisions that arise during the other scenarios are judged as well.

// File: rtl/irq_ack_latch_pkg.sv
package irq_ack_latch_pkg;

    typedef enum logic [1:0] {
        OP_ACK      = 2'd0,
        OP_SET_MASK = 2'd1,
        OP_SET_POLL = 2'd2,
        OP_POLL_OFF = 2'd3
    } cmd_op_e;

    localparam int          BIT_PERIPH   = 4;
    localparam int          BIT_AUTO     = 2;
    localparam int          BIT_TICK     = 5;
    localparam logic [7:0]  PERIPH_FLAGS = 8'h14;
    localparam logic [7:0]  TICK_FLAG    = 8'h20;
    localparam logic [7:0]  MASK_RESET   = 8'h30;

    typedef struct packed {
        logic ack;
        logic set_mask;
        logic set_poll;
        logic poll_off;
    } cmd_dec_t;

    function automatic cmd_dec_t decode_cmd(input logic go, input logic [1:0] op,
                                            input logic [2:0] nargs);
        cmd_dec_t d;
        d = '0;
        if (go) begin
            case (cmd_op_e'(op))
                OP_ACK:      d.ack      = (nargs == 3'd0);
                OP_SET_MASK: d.set_mask = (nargs == 3'd1);
                OP_SET_POLL: d.set_poll = (nargs == 3'd2);
                OP_POLL_OFF: d.poll_off = (nargs == 3'd0);
                default:     d = '0;
            endcase
        end
        return d;
    endfunction

    function automatic logic [7:0] ack_clear_bits(input logic [7:0] pend);
        return pend[BIT_PERIPH] ? PERIPH_FLAGS : 8'hFF;
    endfunction

    function automatic logic [7:0] ack_header(input logic [7:0] pend);
        return pend[BIT_PERIPH] ? (pend & PERIPH_FLAGS) : pend;
    endfunction

endpackage

// File: rtl/irq_period_timer.sv
module irq_period_timer #(
    parameter int PERIOD = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic restart,
    output logic fire
);
    localparam int            CW   = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    assign fire = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart || !en || (cnt == LAST)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    generate
        if (PERIOD > 1) begin : g_spacing
            // R3 / R4: expiries never fall on consecutive cycles
            p_fire_spacing_r3: assert property (@(posedge clk) disable iff (rst)
                fire |=> !fire)
                else $error("timer fired twice in a row");
        end
    endgenerate

endmodule

// File: rtl/irq_evt_core.sv
module irq_evt_core
    import irq_ack_latch_pkg::*;
#(
    parameter int REPLY_BYTES = 16,
    parameter int LEN_W       = $clog2(REPLY_BYTES + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick_fire,
    input  logic                     poll_fire,
    input  logic                     busy,
    input  logic                     ack_go,
    input  logic                     mask_go,
    input  logic [7:0]               mask_val,
    input  logic [LEN_W-1:0]         poll_len,
    input  logic [REPLY_BYTES*8-1:0] poll_data,
    output logic                     poll_req,
    output logic [7:0]               pend,
    output logic [7:0]               ack_hdr,
    output logic [LEN_W-1:0]         ack_nbytes,
    output logic [REPLY_BYTES*8-1:0] rbuf,
    output logic                     irq_n
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(REPLY_BYTES);

    logic [7:0]       mask;
    logic [LEN_W-1:0] rlen;
    logic [LEN_W-1:0] len_c;
    logic             take;
    logic [7:0]       set_bits;
    logic [7:0]       clr_bits;

    assign poll_req   = poll_fire && !pend[BIT_PERIPH] && !busy;
    assign take       = poll_req && (poll_len != '0);
    assign len_c      = (poll_len > MAX_LEN) ? MAX_LEN : poll_len;
    assign set_bits   = (tick_fire ? TICK_FLAG : 8'h00) | (take ? PERIPH_FLAGS : 8'h00);
    assign clr_bits   = ack_go ? ack_clear_bits(pend) : 8'h00;
    assign ack_hdr    = ack_header(pend);
    assign ack_nbytes = pend[BIT_PERIPH] ? rlen : '0;
    assign irq_n      = ~|(pend & mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            mask <= MASK_RESET;
            rlen <= '0;
            rbuf <= '0;
        end else begin
            pend <= (pend & ~clr_bits) | set_bits;
            if (mask_go) begin
                mask <= mask_val;
            end
            if (take) begin
                rlen <= len_c;
                rbuf <= poll_data;
            end else if (ack_go && pend[BIT_PERIPH]) begin
                rlen <= '0;
            end
        end
    end

    p_tick_latch_r3: assert property (@(posedge clk) disable iff (rst)
        tick_fire |=> pend[BIT_TICK])
        else $error("tick not latched");

    p_take_latch_r4: assert property (@(posedge clk) disable iff (rst)
        take |=> (pend[BIT_PERIPH] && pend[BIT_AUTO]))
        else $error("poll capture not latched");

    p_ack_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_go && !pend[BIT_PERIPH] && !tick_fire && !take) |=> (pend == 8'h00))
        else $error("plain acknowledge left bits set");

    p_keep_new_r10: assert property (@(posedge clk) disable iff (rst)
        (ack_go && tick_fire) |=> pend[BIT_TICK])
        else $error("tick lost under acknowledge");

    p_irq_src_r1: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (pend != 8'h00))
        else $error("interrupt without pending bit");

endmodule

// File: rtl/irq_rsp_stream.sv
module irq_rsp_stream #(
    parameter int REPLY_BYTES = 16,
    parameter int LEN_W       = $clog2(REPLY_BYTES + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [7:0]               hdr,
    input  logic [LEN_W-1:0]         nbytes,
    input  logic [REPLY_BYTES*8-1:0] rbuf,
    output logic                     valid,
    output logic [7:0]               data,
    output logic                     last,
    output logic                     busy
);
    localparam int IDX_W = (REPLY_BYTES > 1) ? $clog2(REPLY_BYTES) : 1;

    typedef struct packed {
        logic             valid;
        logic             last;
        logic [7:0]       data;
        logic [IDX_W-1:0] idx;
        logic [LEN_W-1:0] remain;
    } stream_t;

    stream_t    st;
    logic [7:0] bytes [REPLY_BYTES];

    generate
        for (genvar g = 0; g < REPLY_BYTES; g++) begin : g_unpack
            assign bytes[g] = rbuf[g*8 +: 8];
        end
    endgenerate

    assign valid = st.valid;
    assign data  = st.data;
    assign last  = st.last;
    assign busy  = st.valid && !st.last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (start) begin
            st.valid  <= 1'b1;
            st.data   <= hdr;
            st.last   <= (nbytes == '0);
            st.idx    <= '0;
            st.remain <= nbytes;
        end else if (st.valid && !st.last) begin
            st.data   <= bytes[st.idx];
            st.idx    <= st.idx + 1'b1;
            st.remain <= st.remain - 1'b1;
            st.last   <= (st.remain == LEN_W'(1));
        end else begin
            st.valid <= 1'b0;
            st.last  <= 1'b0;
        end
    end

    p_stream_cont_r7: assert property (@(posedge clk) disable iff (rst)
        (valid && !last) |=> valid)
        else $error("response stream broke off");

    p_no_start_busy_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start)
        else $error("command accepted mid-stream");

endmodule

// File: rtl/irq_ack_latch.sv
module irq_ack_latch
    import irq_ack_latch_pkg::*;
#(
    parameter int CYC_PER_MS  = 8,
    parameter int TICK_MS     = 1000,
    parameter int POLL_MS     = 30,
    parameter int REPLY_BYTES = 16,
    parameter int LEN_W       = $clog2(REPLY_BYTES + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_op,
    input  logic [2:0]               cmd_nargs,
    input  logic [15:0]              cmd_arg,
    output logic                     cmd_ready,
    output logic                     poll_req,
    input  logic [LEN_W-1:0]         poll_len,
    input  logic [REPLY_BYTES*8-1:0] poll_data,
    output logic                     rsp_valid,
    output logic [7:0]               rsp_data,
    output logic                     rsp_last,
    output logic                     irq_n
);
    localparam int TICK_CYC = TICK_MS * CYC_PER_MS;
    localparam int POLL_CYC = POLL_MS * CYC_PER_MS;

    logic                     busy;
    cmd_dec_t                 dec;
    logic [15:0]              pmask;
    logic                     poll_restart;
    logic                     tick_fire;
    logic                     poll_fire;
    logic [7:0]               pend;
    logic [7:0]               ack_hdr;
    logic [LEN_W-1:0]         ack_nbytes;
    logic [REPLY_BYTES*8-1:0] rbuf;

    assign cmd_ready    = !busy;
    assign dec          = decode_cmd(cmd_valid && !busy, cmd_op, cmd_nargs);
    assign poll_restart = dec.set_poll && (cmd_arg != pmask);

    always_ff @(posedge clk) begin
        if (rst) begin
            pmask <= '0;
        end else if (poll_restart) begin
            pmask <= cmd_arg;
        end else if (dec.poll_off) begin
            pmask <= '0;
        end
    end

    irq_period_timer #(.PERIOD(TICK_CYC)) u_tick (
        .clk(clk), .rst(rst), .en(1'b1), .restart(1'b0), .fire(tick_fire)
    );

    irq_period_timer #(.PERIOD(POLL_CYC)) u_poll (
        .clk(clk), .rst(rst), .en(|pmask), .restart(poll_restart), .fire(poll_fire)
    );

    irq_evt_core #(.REPLY_BYTES(REPLY_BYTES), .LEN_W(LEN_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .tick_fire  (tick_fire),
        .poll_fire  (poll_fire),
        .busy       (busy),
        .ack_go     (dec.ack),
        .mask_go    (dec.set_mask),
        .mask_val   (cmd_arg[7:0]),
        .poll_len   (poll_len),
        .poll_data  (poll_data),
        .poll_req   (poll_req),
        .pend       (pend),
        .ack_hdr    (ack_hdr),
        .ack_nbytes (ack_nbytes),
        .rbuf       (rbuf),
        .irq_n      (irq_n)
    );

    irq_rsp_stream #(.REPLY_BYTES(REPLY_BYTES), .LEN_W(LEN_W)) u_stream (
        .clk    (clk),
        .rst    (rst),
        .start  (dec.ack),
        .hdr    (ack_hdr),
        .nbytes (ack_nbytes),
        .rbuf   (rbuf),
        .valid  (rsp_valid),
        .data   (rsp_data),
        .last   (rsp_last),
        .busy   (busy)
    );

    p_hdr_flags_r5: assert property (@(posedge clk) disable iff (rst)
        (dec.ack && pend[BIT_PERIPH]) |=> (rsp_valid && (rsp_data == ($past(pend) & PERIPH_FLAGS))))
        else $error("peripheral acknowledge header wrong");

    p_single_byte_r6: assert property (@(posedge clk) disable iff (rst)
        (dec.ack && !pend[BIT_PERIPH]) |=> (rsp_valid && rsp_last && (rsp_data == $past(pend))))
        else $error("plain acknowledge byte wrong");

    p_poll_stop_r9: assert property (@(posedge clk) disable iff (rst)
        (pmask == 16'h0000) |-> !poll_req)
        else $error("poll request with polling stopped");

endmodule

// File: tb/irq_ack_latch_bench.sv
`timescale 1ns/1ps
module irq_ack_latch_bench;
    localparam int CPM = 2;
    localparam int TMS = 100;
    localparam int PMS = 30;
    localparam int RB  = 16;
    localparam int LW  = $clog2(RB + 1);
    localparam int TP  = TMS * CPM;
    localparam int PP  = PMS * CPM;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cmd_valid = 1'b0;
    logic [1:0]      cmd_op = '0;
    logic [2:0]      cmd_nargs = '0;
    logic [15:0]     cmd_arg = '0;
    logic            cmd_ready;
    logic            poll_req;
    logic [LW-1:0]   poll_len = '0;
    logic [RB*8-1:0] poll_data = '0;
    logic            rsp_valid;
    logic [7:0]      rsp_data;
    logic            rsp_last;
    logic            irq_n;

    always #2.5 clk = ~clk;

    irq_ack_latch #(.CYC_PER_MS(CPM), .TICK_MS(TMS), .POLL_MS(PMS), .REPLY_BYTES(RB)) u_irq_ack_latch (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_nargs(cmd_nargs),
        .cmd_arg(cmd_arg), .cmd_ready(cmd_ready), .poll_req(poll_req), .poll_len(poll_len),
        .poll_data(poll_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .irq_n(irq_n)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model state
    logic [7:0]  m_pend, m_mask;
    logic [15:0] m_pmask;
    int          m_tcnt, m_pcnt, m_rlen, cyc;
    logic [7:0]  m_buf [RB];
    logic [7:0]  m_q [$];

    always @(posedge clk) begin
        logic [7:0]  setb, clrb;
        logic [15:0] pm_old;
        bit          mb, tf, pf, pr, take, rpc;
        int          ln;
        if (rst) begin
            m_pend = 8'h00; m_mask = 8'h30; m_pmask = 16'h0;
            m_tcnt = 0; m_pcnt = 0; m_rlen = 0; cyc = 0;
            m_q.delete();
        end else begin
            cyc++;
            pm_old = m_pmask;
            mb   = (m_q.size() > 1);
            tf   = (m_tcnt == TP - 1);
            pf   = (m_pmask != 0) && (m_pcnt == PP - 1);
            pr   = pf && !m_pend[4] && !mb;
            ln   = (int'(poll_len) > RB) ? RB : int'(poll_len);
            take = pr && (ln > 0);
            setb = 8'h00; clrb = 8'h00; rpc = 1'b0;
            if (tf)   setb = setb | 8'h20;
            if (take) setb = setb | 8'h14;
            if (m_q.size() > 0) void'(m_q.pop_front());
            if (cmd_valid && !mb) begin
                case (cmd_op)
                    2'd0: if (cmd_nargs == 0) begin
                        if (m_pend[4]) begin
                            m_q.push_back(m_pend & 8'h14);
                            for (int i = 0; i < m_rlen; i++) m_q.push_back(m_buf[i]);
                            clrb = 8'h14;
                            m_rlen = 0;
                        end else begin
                            m_q.push_back(m_pend);
                            clrb = 8'hFF;
                        end
                    end
                    2'd1: if (cmd_nargs == 1) m_mask = cmd_arg[7:0];
                    2'd2: if (cmd_nargs == 2 && cmd_arg != m_pmask) begin
                        m_pmask = cmd_arg;
                        rpc = 1'b1;
                    end
                    default: if (cmd_nargs == 0) m_pmask = 16'h0;
                endcase
            end
            if (take) begin
                m_rlen = ln;
                for (int i = 0; i < ln; i++) m_buf[i] = poll_data[i*8 +: 8];
            end
            m_pend = (m_pend & ~clrb) | setb;
            m_tcnt = tf ? 0 : m_tcnt + 1;
            if (rpc || pm_old == 0 || m_pcnt == PP - 1) m_pcnt = 0;
            else m_pcnt = m_pcnt + 1;
        end
    end

    // per-cycle comparison and collectors
    logic [7:0] got [$];
    int         pulses [$];

    always @(negedge clk) begin
        bit eb;
        if (!rst) begin
            eb = (m_q.size() > 1);
            chk(irq_n == ~|(m_pend & m_mask), "R1 irq_n", irq_n, ~|(m_pend & m_mask));
            chk(cmd_ready == !eb, "R7 cmd_ready", cmd_ready, !eb);
            chk(rsp_valid == (m_q.size() > 0), "R7 rsp_valid", rsp_valid, m_q.size() > 0);
            if (m_q.size() > 0) begin
                chk(rsp_data == m_q[0], "R5 rsp_data", rsp_data, m_q[0]);
                chk(rsp_last == (m_q.size() == 1), "R7 rsp_last", rsp_last, m_q.size() == 1);
            end
            chk(poll_req == ((m_pmask != 0) && (m_pcnt == PP - 1) && !m_pend[4] && !eb),
                "R4 poll_req", poll_req, (m_pmask != 0) && (m_pcnt == PP - 1) && !m_pend[4] && !eb);
            if (rsp_valid) got.push_back(rsp_data);
            if (poll_req) pulses.push_back(cyc);
        end
    end

    task automatic send(input logic [1:0] op, input logic [2:0] na, input logic [15:0] arg);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_nargs = na; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // acknowledge and compare the stream with the pending state seen at issue
    task automatic do_ack(input string tag);
        logic [7:0] exp [$];
        exp.delete();
        if (m_pend[4]) begin
            exp.push_back(m_pend & 8'h14);
            for (int i = 0; i < m_rlen; i++) exp.push_back(m_buf[i]);
        end else begin
            exp.push_back(m_pend);
        end
        got.delete();
        send(2'd0, 3'd0, 16'h0);
        repeat (RB + 6) @(negedge clk);
        chk(got.size() == exp.size(), tag, got.size(), exp.size());
        for (int i = 0; i < exp.size() && i < got.size(); i++)
            chk(got[i] == exp[i], tag, got[i], exp[i]);
    endtask

    initial begin
        int t0, a;
        logic [7:0] snap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        chk(irq_n == 1'b1, "R2 irq_n", irq_n, 1);
        chk(cmd_ready == 1'b1, "R2 cmd_ready", cmd_ready, 1);
        chk(rsp_valid == 1'b0, "R2 rsp_valid", rsp_valid, 0);
        chk(poll_req == 1'b0, "R2 poll_req", poll_req, 0);

        // R8: wrong argument counts must leave the mask at its reset value
        send(2'd1, 3'd0, 16'h0000);
        send(2'd1, 3'd2, 16'h0000);
        send(2'd0, 3'd1, 16'h0000);
        chk(rsp_valid == 1'b0, "R8 ack with args", rsp_valid, 0);
        while (!m_pend[5]) @(negedge clk);
        chk(cyc == TP, "R3 first tick edge", cyc, TP);
        chk(irq_n == 1'b0, "R8 mask kept tick enable", irq_n, 0);
        t0 = cyc;
        do_ack("R6 tick ack");
        chk(got.size() > 0 && got[0] == 8'h20, "R6 tick byte", got.size() > 0 ? got[0] : 8'hxx, 8'h20);
        chk(irq_n == 1'b1, "R6 cleared", irq_n, 1);

        // R1: masked pending bit keeps the line high
        send(2'd1, 3'd1, 16'h0000);
        while (!m_pend[5]) @(negedge clk);
        chk(cyc - t0 == TP, "R3 no drift", cyc - t0, TP);
        chk(irq_n == 1'b1, "R1 masked", irq_n, 1);
        send(2'd1, 3'd1, 16'h00FF);
        chk(irq_n == 1'b0, "R1 unmasked", irq_n, 0);
        do_ack("R6 masked tick");

        // R4 / R5: autopoll capture and peripheral acknowledge
        poll_len = LW'(3);
        poll_data = '0;
        poll_data[23:0] = 24'hC3B2A1;
        send(2'd2, 3'd2, 16'h0001);
        while (!m_pend[4]) @(negedge clk);
        chk(irq_n == 1'b0, "R4 capture raises irq", irq_n, 0);
        poll_len = '0;
        do_ack("R5 reply stream");
        chk(got.size() == 4 && got[0] == 8'h14 && got[3] == 8'hC3, "R5 flags and bytes",
            got.size(), 4);

        // R4: reply length clamps at the buffer size
        poll_len = LW'(20);
        for (int i = 0; i < RB; i++) poll_data[i*8 +: 8] = 8'(i + 8'h40);
        while (!m_pend[4]) @(negedge clk);
        poll_len = '0;
        do_ack("R4 clamped reply");
        chk(got.size() == RB + 1, "R4 clamp length", got.size(), RB + 1);

        // R9: period, same-mask rewrite, restart, stop
        pulses.delete();
        while (pulses.size() < 2) @(negedge clk);
        chk(pulses[1] - pulses[0] == PP, "R4 poll period", pulses[1] - pulses[0], PP);
        repeat (20) @(negedge clk);
        send(2'd2, 3'd2, 16'h0001);
        while (pulses.size() < 3) @(negedge clk);
        chk(pulses[2] - pulses[1] == PP, "R9 same mask no restart", pulses[2] - pulses[1], PP);
        repeat (20) @(negedge clk);
        send(2'd2, 3'd2, 16'h0002);
        a = cyc;
        while (pulses.size() < 4) @(negedge clk);
        chk(pulses[3] == a + PP - 1, "R9 restart on new mask", pulses[3], a + PP - 1);
        send(2'd3, 3'd0, 16'h0);
        pulses.delete();
        repeat (3 * PP) @(negedge clk);
        chk(pulses.size() == 0, "R9 poll off", pulses.size(), 0);

        // R10: acknowledge on the tick edge
        while (!(m_tcnt == TP - 1 && cmd_ready && m_q.size() == 0)) @(negedge clk);
        snap = m_pend;
        got.delete();
        send(2'd0, 3'd0, 16'h0);
        repeat (4) @(negedge clk);
        chk(got.size() == 1 && got[0] == snap, "R10 ack returns old value", got.size() > 0 ? got[0] : 8'hxx, snap);
        chk(irq_n == 1'b0, "R10 tick survives", irq_n, 0);
        do_ack("R10 tick follow-up");
        chk(got.size() > 0 && got[0][5], "R10 tick bit returned", got.size() > 0 ? got[0] : 8'hxx, 8'h20);

        // R10: acknowledge on a poll capture edge
        poll_len = LW'(2);
        poll_data[15:0] = 16'h5A6B;
        send(2'd2, 3'd2, 16'h0004);
        while (!(m_pmask != 0 && m_pcnt == PP - 1 && !m_pend[4] && m_tcnt != TP - 1 && m_q.size() == 0))
            @(negedge clk);
        snap = m_pend;
        got.delete();
        send(2'd0, 3'd0, 16'h0);
        poll_len = '0;
        repeat (4) @(negedge clk);
        chk(got.size() == 1 && got[0] == snap, "R10 ack beside capture", got.size() > 0 ? got[0] : 8'hxx, snap);
        do_ack("R10 capture kept");
        chk(got.size() == 3 && got[0] == 8'h14, "R10 capture stream", got.size(), 3);
        send(2'd3, 3'd0, 16'h0);
        repeat (5) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule